// File: doc/BRIEF.md
# Stream-to-register receive unpacker

This block lets a processor collect received frames one 32-bit word at a time. Frames arrive on a valid/ready packet stream that carries a byte strobe, an end-of-frame flag and two 8-bit port maps with each beat. Every accepted beat goes into an on-chip word FIFO. A frame is released to the processor only once its final beat has been stored. Software works through a small read window with three registers: data, metadata and length.

Reading the data register returns the word at the FIFO head and moves to the next word. The metadata register describes the head word. The length register gives the frame's byte count, but only while the head word is the first word of a frame; in the middle of a frame it reads zero. Software can therefore find the next frame boundary by checking for a zero length together with a nonzero strobe. A frame that cannot fit in the FIFO is discarded as a whole, and a saturating counter records each discarded frame.

Top module: `pio_rx_unpacker`

## Requirements
- R1: After reset, `s_ready` is 1 and `drop_count` is 0. Reads of the data, metadata and length registers all return 0.
- R2: A read at byte offset 0x0 returns the head word in big-endian order and then advances to the next word. In this order, stream byte 0 (`s_data[7:0]`) appears in bits 31:24. Reads at offsets 0x4 and 0x8 never advance the head.
- R3: The metadata word at offset 0x4 is laid out as follows:
  - bits 31:24 carry the destination map;
  - bits 23:16 carry the source map;
  - bit 7 carries the end-of-frame flag;
  - bits 3:0 carry the byte strobe of the head word;
  - all other bits are 0.
- R4: The length at offset 0x8 is the number of set strobe bits summed over the whole frame, and it is shown only while the head word opens a frame. On any later word of the frame the length reads 0 while the strobe reads nonzero.
- R5: A frame is invisible until its final beat has been stored. While only part of a frame is held, the metadata and length registers read 0.
- R6: A frame that overflows the FIFO is discarded in full and `drop_count` increases by one. Frames committed earlier stay intact, and the frame that follows is received normally.
- R7: `s_ready` goes low only when no frame is in progress and the FIFO is full. Once a frame's first beat is accepted, every later beat of that frame is accepted.
- R8: A data read while no word is visible returns 0 and changes nothing.
- R9: Each read value appears on `rd_data` in the cycle after `rd_en` and holds there until the next read. Offset 0xC reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | 32 | Beat payload, byte 0 in bits 7:0 |
| s_keep | input | 4 | Byte strobe, contiguous from bit 0 on the final beat |
| s_last | input | 1 | Final beat of the frame |
| s_dst | input | 8 | Destination port map |
| s_src | input | 8 | Source port map |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register byte offset |
| rd_data | output | 32 | Registered read value |
| drop_count | output | DROP_W | Saturating count of discarded frames |

## Verification
Two things can happen in the same cycle: a frame's final beat is committed, and the processor reads the length or metadata. The bench provokes this by driving the last stream beat and a length read on the same clock edge. It then expects that read to return 0, because the frame was not yet visible, and expects the next read to return the full byte count. A second overlap comes from driving a frame into a FIFO that is already holding an earlier committed frame. Here the overflow discard must restore the write position without disturbing the words the processor has yet to read, and the bench judges this by reading the earlier frame back word for word after the drop.

// File: rtl/pio_rx_pkg.sv
package pio_rx_pkg;
    localparam int WORD_W = 32;
    localparam int MAP_W  = 8;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_META = 2'd1;
    localparam logic [1:0] SEL_LEN  = 2'd2;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [3:0]        keep;
        logic              last;
        logic              sof;
        logic [MAP_W-1:0]  dst;
        logic [MAP_W-1:0]  src;
    } beat_t;
endpackage

// File: rtl/pio_rx_store.sv
module pio_rx_store
    import pio_rx_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int LEN_W = 13,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  beat_t            wbeat,
    input  logic             len_we,
    input  logic [AW-1:0]    len_waddr,
    input  logic [LEN_W-1:0] len_wval,
    input  logic [AW-1:0]    raddr,
    output beat_t            rbeat,
    output logic [LEN_W-1:0] rlen
);
    beat_t            beat_mem [DEPTH];
    logic [LEN_W-1:0] len_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (we) beat_mem[waddr] <= wbeat;
        if (len_we) len_mem[len_waddr] <= len_wval;
    end

    assign rbeat = beat_mem[raddr];
    assign rlen  = len_mem[raddr];
endmodule

// File: rtl/pio_rx_regs.sv
module pio_rx_regs
    import pio_rx_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic             head_valid,
    input  beat_t            head,
    input  logic [LEN_W-1:0] head_len,
    input  logic [1:0]       sel,
    output logic [31:0]      value
);
    logic [31:0] swapped;

    for (genvar b = 0; b < 4; b++) begin : g_swap
        assign swapped[31-8*b -: 8] = head.data[8*b +: 8];
    end

    always_comb begin
        value = '0;
        if (head_valid) begin
            unique case (sel)
                SEL_DATA: value = swapped;
                SEL_META: value = {head.dst, head.src, 8'h00, head.last, 3'b000, head.keep};
                SEL_LEN:  value = head.sof ? 32'(head_len) : 32'd0;
                default:  value = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio_rx_unpacker.sv
module pio_rx_unpacker
    import pio_rx_pkg::*;
#(
    parameter int DEPTH_WORDS = 1024,
    parameter int DROP_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [31:0]       s_data,
    input  logic [3:0]        s_keep,
    input  logic              s_last,
    input  logic [7:0]        s_dst,
    input  logic [7:0]        s_src,
    input  logic              rd_en,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic [DROP_W-1:0] drop_count
);
    localparam int AW    = $clog2(DEPTH_WORDS);
    localparam int PW    = AW + 1;
    localparam int LEN_W = $clog2(DEPTH_WORDS * 4 + 1);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH_WORDS);

    typedef struct packed {
        logic [PW-1:0]     wr;
        logic [PW-1:0]     cm;
        logic [PW-1:0]     rd;
        logic [PW-1:0]     sof;
        logic              in_frame;
        logic              dropping;
        logic [LEN_W-1:0]  bytes;
        logic [DROP_W-1:0] drops;
        logic [31:0]       rdata;
    } state_t;

    state_t st_d, st_q;

    logic             mem_we, len_we;
    logic [AW-1:0]    len_addr;
    logic [LEN_W-1:0] len_val, new_bytes;
    beat_t            wbeat, head;
    logic [LEN_W-1:0] head_len;
    logic [31:0]      reg_val;
    logic [PW-1:0]    used;
    logic             full, head_valid, beat;
    logic [2:0]       keep_cnt;

    assign used       = st_q.wr - st_q.rd;
    assign full       = (used == DEPTH_P);
    assign head_valid = (st_q.rd != st_q.cm);
    assign s_ready    = st_q.in_frame || st_q.dropping || !full;
    assign beat       = s_valid && s_ready;
    assign keep_cnt   = 3'(s_keep[0]) + 3'(s_keep[1]) + 3'(s_keep[2]) + 3'(s_keep[3]);
    assign new_bytes  = (st_q.in_frame ? st_q.bytes : '0) + LEN_W'(keep_cnt);

    assign wbeat = '{data: s_data, keep: s_keep, last: s_last, sof: !st_q.in_frame,
                     dst: s_dst, src: s_src};

    pio_rx_store #(.DEPTH(DEPTH_WORDS), .LEN_W(LEN_W)) store_i (
        .clk(clk), .we(mem_we), .waddr(st_q.wr[AW-1:0]), .wbeat(wbeat),
        .len_we(len_we), .len_waddr(len_addr), .len_wval(len_val),
        .raddr(st_q.rd[AW-1:0]), .rbeat(head), .rlen(head_len)
    );

    pio_rx_regs #(.LEN_W(LEN_W)) regs_i (
        .head_valid(head_valid), .head(head), .head_len(head_len),
        .sel(rd_addr[3:2]), .value(reg_val)
    );

    always_comb begin
        st_d     = st_q;
        mem_we   = 1'b0;
        len_we   = 1'b0;
        len_addr = st_q.in_frame ? st_q.sof[AW-1:0] : st_q.wr[AW-1:0];
        len_val  = new_bytes;
        if (beat) begin
            if (st_q.dropping) begin
                if (s_last) st_d.dropping = 1'b0;
            end else if (full) begin
                st_d.wr       = st_q.sof;
                st_d.in_frame = 1'b0;
                st_d.dropping = !s_last;
                if (st_q.drops != '1) st_d.drops = st_q.drops + 1'b1;
            end else begin
                mem_we     = 1'b1;
                st_d.wr    = st_q.wr + 1'b1;
                st_d.bytes = new_bytes;
                if (!st_q.in_frame) st_d.sof = st_q.wr;
                if (s_last) begin
                    st_d.cm       = st_q.wr + 1'b1;
                    st_d.in_frame = 1'b0;
                    len_we        = 1'b1;
                end else begin
                    st_d.in_frame = 1'b1;
                end
            end
        end
        if (rd_en) begin
            st_d.rdata = reg_val;
            if (rd_addr[3:2] == SEL_DATA && head_valid) st_d.rd = st_q.rd + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.rdata;
    assign drop_count = st_q.drops;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        used <= DEPTH_P);
    assert_drop_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.drops >= $past(st_q.drops));
    assert_ready_mid_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && !s_last) |=> s_ready);
    assert_pop_only_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr[3:2] == SEL_DATA) |=> $stable(st_q.rd));
    assert_commit_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cm - st_q.rd) <= used);
    assert_empty_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[3:2] == SEL_DATA && !head_valid) |=> (rd_data == 32'd0));
endmodule

// File: tb/pio_rx_unpacker_tb.sv
`timescale 1ns/1ps
module pio_rx_unpacker_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_last = 1'b0, rd_en = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0, rd_data;
    logic [3:0]  s_keep = '0, rd_addr = '0;
    logic [7:0]  s_dst = '0, s_src = '0;
    logic [15:0] drop_count;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    pio_rx_unpacker #(.DEPTH_WORDS(DEPTH), .DROP_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_keep(s_keep), .s_last(s_last), .s_dst(s_dst),
        .s_src(s_src), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .drop_count(drop_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int f, input int b);
        return {8'(f), 8'(b), 8'hA5, 8'(b + 3)};
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic send(input logic [31:0] d, input logic [3:0] k, input logic l,
                        output logic took);
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_keep = k; s_last = l;
        s_dst = 8'h02; s_src = 8'h01;
        took = s_ready;
        @(posedge clk);
        #1 s_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        #1 rd_en = 1'b0;
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 ready", 32'(s_ready), 32'd1);
        chk("R1 drops", 32'(drop_count), 32'd0);
        rd(4'h0, v); chk("R1 data", v, 32'd0);
        rd(4'h4, v); chk("R1 meta", v, 32'd0);
        rd(4'h8, v); chk("R1 len", v, 32'd0);
    endtask

    task automatic t_frame();
        logic [31:0] v; logic tk;
        send(word_of(1, 0), 4'hF, 1'b0, tk);
        send(word_of(1, 1), 4'hF, 1'b0, tk);
        rd(4'h4, v); chk("R5 partial meta", v, 32'd0);
        rd(4'h8, v); chk("R5 partial len", v, 32'd0);
        send(word_of(1, 2), 4'h3, 1'b1, tk);
        rd(4'h8, v); chk("R4 len", v, 32'd10);
        rd(4'h4, v); chk("R3 meta first", v, 32'h0201000F);
        rd(4'h8, v); chk("R2 len no pop", v, 32'd10);
        rd(4'hC, v); chk("R9 unmapped", v, 32'd0);
        rd(4'h0, v); chk("R2 data0", v, bswap(word_of(1, 0)));
        @(negedge clk); chk("R9 hold", rd_data, bswap(word_of(1, 0)));
        rd(4'h8, v); chk("R4 mid len", v, 32'd0);
        rd(4'h4, v); chk("R4 mid strobe", v, 32'h0201000F);
        rd(4'h0, v); chk("R2 data1", v, bswap(word_of(1, 1)));
        rd(4'h4, v); chk("R3 meta last", v, 32'h02010083);
        rd(4'h0, v); chk("R2 data2", v, bswap(word_of(1, 2)));
        rd(4'h0, v); chk("R8 empty data", v, 32'd0);
        rd(4'h4, v); chk("R8 empty meta", v, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk);
        s_valid = 1'b1; s_data = word_of(2, 0); s_keep = 4'h1; s_last = 1'b1;
        rd_en = 1'b1; rd_addr = 4'h8;
        @(posedge clk);
        #1 begin s_valid = 1'b0; rd_en = 1'b0; end
        @(negedge clk);
        chk("R5 same-cycle len", rd_data, 32'd0);
        rd(4'h8, v); chk("R4 single len", v, 32'd1);
        rd(4'h4, v); chk("R3 single meta", v, 32'h02010081);
        rd(4'h0, v); chk("R2 single data", v, bswap(word_of(2, 0)));
    endtask

    task automatic t_overflow();
        logic [31:0] v; logic tk; int refused = 0;
        for (int b = 0; b < 10; b++) send(word_of(3, b), 4'hF, b == 9, tk);
        for (int b = 0; b < 10; b++) begin
            send(word_of(4, b), 4'hF, b == 9, tk);
            if (!tk) refused++;
        end
        chk("R7 mid-frame refusals", 32'(refused), 32'd0);
        chk("R6 drop count", 32'(drop_count), 32'd1);
        rd(4'h8, v); chk("R6 prior len", v, 32'd40);
        for (int b = 0; b < 10; b++) begin
            rd(4'h0, v); chk("R6 prior data", v, bswap(word_of(3, b)));
        end
        rd(4'h4, v); chk("R6 dropped invisible", v, 32'd0);
        send(word_of(5, 0), 4'h7, 1'b1, tk);
        rd(4'h8, v); chk("R6 next len", v, 32'd3);
        rd(4'h0, v); chk("R6 next data", v, bswap(word_of(5, 0)));
    endtask

    task automatic t_full();
        logic [31:0] v; logic tk;
        for (int b = 0; b < DEPTH; b++) send(word_of(6, b), 4'hF, b == DEPTH - 1, tk);
        @(negedge clk); chk("R7 idle full ready", 32'(s_ready), 32'd0);
        rd(4'h8, v); chk("R7 exact fit len", v, 32'(DEPTH * 4));
        rd(4'h0, v); chk("R2 full data", v, bswap(word_of(6, 0)));
        chk("R7 ready after pop", 32'(s_ready), 32'd1);
        chk("R6 drops unchanged", 32'(drop_count), 32'd1);
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_frame();
        t_collide();
        t_overflow();
        t_full();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule